// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge gives a host a path into an internal register space that is too large or too slow to map directly. The host sees five 32-bit window registers on a simple register interface: a target address, a write data word, a command, a completion flag and a captured read value. To reach an internal register the host fills in the address (and, for a write, the data), then writes a command code. The bridge runs exactly one access on an internal request/acknowledge port, whose target may take any number of cycles to answer, and then sets the completion flag. The host polls that flag, collects read data if it asked for a read, and writes zero to the command register to close the transaction.

While a command is open the bridge locks its address and data registers, so that a host misbehaving during the access cannot alter what the target sees. If the target never answers, the completion flag simply stays low, and the host's own poll limit decides when to give up. Writing zero to the command register while the access is still pending does not cut the internal handshake short. The request is held until the target acknowledges, and the bridge then goes back to idle without signalling completion.

Top module: `irb_bridge`

## Requirements
- R1: Host word offsets are 0 target address, 1 write data, 2 command, 3 completion flag, 4 read data; offsets 5 to 7 read as zero. A read strobe returns the selected value on host_rdata in the following cycle, and every window register reads zero after reset.
- R2: Writing code 2 to the command register while idle starts one internal write with the window address and data. The completion flag reads 1 only after the target has acknowledged that write.
- R3: Writing code 1 to the command register while idle starts one internal read. Once the completion flag reads 1, the read data register holds the acknowledged value. A completed write leaves the read data register unchanged.
- R4: Writing zero to the command register while complete returns the bridge to idle. In the next cycle the completion flag reads 0 and the command register reads 0.
- R5: A command write of any value other than 0, 1 or 2 while idle starts nothing: no request is raised and the command register keeps reading 0. A nonzero command write while an access is open is also ignored, and the command register keeps the original code.
- R6: Writes to the address and write data registers while a command is open are ignored, both on the internal port and in the window readback.
- R7: ireq stays high with iaddr, iwdata and iwe stable from the cycle it rises until the cycle iack is seen. Each command produces exactly one acknowledged access.
- R8: Writing zero to the command register while the request is still unacknowledged keeps ireq high until iack. The bridge then returns to idle with the completion flag at 0, and the access takes effect at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | HOST_AW (3) | Host word offset into the window |
| host_wdata | input | DATA_W (32) | Host write data |
| host_rdata | output | DATA_W (32) | Host read data, valid the cycle after host_re |
| ireq | output | 1 | Internal access request |
| iwe | output | 1 | Internal access is a write |
| iaddr | output | IADDR_W (16) | Internal register address |
| iwdata | output | DATA_W (32) | Internal write data |
| iack | input | 1 | Internal access acknowledge, one cycle |
| irdata | input | DATA_W (32) | Internal read data, valid with iack |

## Verification
The bench targets a slow or stalled target. With the target stalled, it writes new address, data and command values into the window. A bridge that failed to lock those registers would send a different address to the target, or switch a write into a read. A bridge that did not gate completion on iack would report completion while the target was frozen. The bench also closes a command before the acknowledge arrives. A bridge that dropped the request early would lose the write, and one that ignored the early close would show a completion nobody asked for. Finally, it checks that reserved command codes and completed writes leave the read data register and the request line untouched.

// File: rtl/irb_pkg.sv
package irb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DONE} irb_state_t;

  // host window word offsets
  localparam int OFS_ADDR  = 0;
  localparam int OFS_WDATA = 1;
  localparam int OFS_CMD   = 2;
  localparam int OFS_DONE  = 3;
  localparam int OFS_RDATA = 4;

  // command codes
  localparam int CMD_RD = 1;
  localparam int CMD_WR = 2;
endpackage

// File: rtl/irb_seq.sv
module irb_seq
  import irb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_val,
  input  logic              iack,
  output logic              ireq,
  output logic              iwe,
  output logic              done,
  output logic              busy,
  output logic              capture,
  output logic [DATA_W-1:0] cmd_q
);
  irb_state_t state_q;
  logic       abort_q;
  logic       is_rd, is_wr, is_zero;

  assign is_rd   = (cmd_val == DATA_W'(CMD_RD));
  assign is_wr   = (cmd_val == DATA_W'(CMD_WR));
  assign is_zero = (cmd_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ireq    <= 1'b0;
      iwe     <= 1'b0;
      done    <= 1'b0;
      abort_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_wr && (is_rd || is_wr)) begin
            state_q <= ST_REQ;
            ireq    <= 1'b1;
            iwe     <= is_wr;
            cmd_q   <= cmd_val;
            abort_q <= 1'b0;
          end
        end
        ST_REQ: begin
          // host closes early: remember it, but keep the handshake intact
          if (cmd_wr && is_zero) begin
            abort_q <= 1'b1;
            cmd_q   <= '0;
          end
          if (iack) begin
            ireq <= 1'b0;
            if (abort_q || (cmd_wr && is_zero)) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DONE;
              done    <= 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (cmd_wr && is_zero) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            cmd_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign capture = (state_q == ST_REQ) && iack && !iwe;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/irb_window.sv
module irb_window
  import irb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int HOST_AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic               host_re,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               busy,
  input  logic               done,
  input  logic [DATA_W-1:0]  cmd_q,
  input  logic               capture,
  input  logic [DATA_W-1:0]  cap_data,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [IADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0]  wdata_q
);
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (host_addr == HOST_AW'(OFS_ADDR))       rd_mux = DATA_W'(addr_q);
    else if (host_addr == HOST_AW'(OFS_WDATA)) rd_mux = wdata_q;
    else if (host_addr == HOST_AW'(OFS_CMD))   rd_mux = cmd_q;
    else if (host_addr == HOST_AW'(OFS_DONE))  rd_mux = DATA_W'(done);
    else if (host_addr == HOST_AW'(OFS_RDATA)) rd_mux = rdata_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      host_rdata <= '0;
    end else begin
      // locked while an access is open
      if (host_we && !busy) begin
        if (host_addr == HOST_AW'(OFS_ADDR))  addr_q  <= host_wdata[IADDR_W-1:0];
        if (host_addr == HOST_AW'(OFS_WDATA)) wdata_q <= host_wdata;
      end
      if (capture) rdata_q <= cap_data;
      if (host_re) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irb_bridge.sv
module irb_bridge
  import irb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int HOST_AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic               host_re,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               ireq,
  output logic               iwe,
  output logic [IADDR_W-1:0] iaddr,
  output logic [DATA_W-1:0]  iwdata,
  input  logic               iack,
  input  logic [DATA_W-1:0]  irdata
);
  logic              cmd_wr;
  logic              busy;
  logic              cmd_done;
  logic              capture;
  logic [DATA_W-1:0] cmd_q;

  assign cmd_wr = host_we && (host_addr == HOST_AW'(OFS_CMD));

  irb_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (cmd_wr),
    .cmd_val (host_wdata),
    .iack    (iack),
    .ireq    (ireq),
    .iwe     (iwe),
    .done    (cmd_done),
    .busy    (busy),
    .capture (capture),
    .cmd_q   (cmd_q)
  );

  irb_window #(.DATA_W(DATA_W), .IADDR_W(IADDR_W), .HOST_AW(HOST_AW)) u_win (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .done       (cmd_done),
    .cmd_q      (cmd_q),
    .capture    (capture),
    .cap_data   (irdata),
    .host_rdata (host_rdata),
    .addr_q     (iaddr),
    .wdata_q    (iwdata)
  );
endmodule

// File: rtl/irb_checker.sv
module irb_checker
  import irb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int HOST_AW = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic               ireq,
  input logic               iack,
  input logic               iwe,
  input logic [IADDR_W-1:0] iaddr,
  input logic [DATA_W-1:0]  iwdata,
  input logic               cmd_done,
  input logic               busy
);
  logic cmd_zero_wr, addr_wr, bad_cmd_wr;
  assign cmd_zero_wr = host_we && host_addr == HOST_AW'(OFS_CMD) && host_wdata == '0;
  assign addr_wr     = host_we && host_addr == HOST_AW'(OFS_ADDR);
  assign bad_cmd_wr  = host_we && host_addr == HOST_AW'(OFS_CMD) &&
                       host_wdata != DATA_W'(CMD_RD) && host_wdata != DATA_W'(CMD_WR);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    ireq && !iack |=> ireq && $stable(iaddr) && $stable(iwdata) && $stable(iwe)); // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_done) |-> $past(iack)); // R2
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> !ireq); // R2
  AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_zero_wr |=> !cmd_done); // R4
  AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy && bad_cmd_wr |=> !ireq && !busy); // R5
  AST_ADDR_LOCK: assert property (@(posedge clk) disable iff (rst)
    busy && addr_wr |=> $stable(iaddr)); // R6
  AST_EARLY_CLOSE: assert property (@(posedge clk) disable iff (rst)
    ireq && !iack && cmd_zero_wr |=> ireq); // R8
endmodule

bind irb_bridge irb_checker #(.DATA_W(DATA_W), .IADDR_W(IADDR_W), .HOST_AW(HOST_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .ireq       (ireq),
  .iack       (iack),
  .iwe        (iwe),
  .iaddr      (iaddr),
  .iwdata     (iwdata),
  .cmd_done   (cmd_done),
  .busy       (busy)
);

// File: tb/test_irb_bridge.sv
`timescale 1ns/1ps
module test_irb_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ireq, iwe, iack;
  logic [15:0] iaddr;
  logic [31:0] iwdata, irdata;

  int n_chk = 0, n_fail = 0, n_acc = 0;
  logic        stall = 1'b0;
  int          wait_cnt = 0;
  logic [31:0] mem    [16];
  logic [31:0] shadow [16];
  logic [31:0] last_rd = '0;

  always #4 clk = ~clk;

  irb_bridge i_irb_bridge (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ireq(ireq), .iwe(iwe), .iaddr(iaddr), .iwdata(iwdata),
    .iack(iack), .irdata(irdata)
  );

  // internal register target with random latency
  always @(posedge clk) begin
    if (rst) begin
      iack     <= 1'b0;
      irdata   <= '0;
      wait_cnt <= 0;
    end else begin
      iack <= 1'b0;
      if (ireq && !iack && !stall) begin
        if (wait_cnt == 0) begin
          iack <= 1'b1;
          if (iwe) mem[iaddr[3:0]] <= iwdata;
          else     irdata <= mem[iaddr[3:0]];
          wait_cnt <= $urandom_range(0, 5);
          n_acc    <= n_acc + 1;
        end else begin
          wait_cnt <= wait_cnt - 1;
        end
      end
    end
  end

  function automatic logic [31:0] init_word(input int i);
    return 32'h1111_1111 * i + 32'h0A00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a[2:0]; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a[2:0];
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic poll_done(output logic ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int k = 0; k < 64 && !ok; k++) begin
      hrd(3, v);
      if (v != 0) ok = 1'b1;
    end
  endtask

  task automatic access(input logic wr, input int a, input logic [31:0] d);
    logic [31:0] v;
    logic ok;
    int acc0;
    acc0 = n_acc;
    hwr(0, a);
    if (wr) hwr(1, d);
    hwr(2, wr ? 2 : 1);
    poll_done(ok);
    check(wr ? "R2 completion seen" : "R3 completion seen", {31'b0, ok}, 32'd1);
    hrd(4, v);
    if (wr) begin
      shadow[a] = d;
      check("R3 write leaves read data", v, last_rd);
    end else begin
      check("R3 read value", v, shadow[a]);
      last_rd = shadow[a];
    end
    check("R7 one access per command", n_acc, acc0 + 1);
    hwr(2, 0);
    hrd(3, v);
    check("R4 flag cleared", v, 32'd0);
    hrd(2, v);
    check("R4 command cleared", v, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic ok;
    int acc0;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) begin
      mem[i] = init_word(i);
      shadow[i] = init_word(i);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and window map
    for (int a = 0; a < 8; a++) begin
      hrd(a, v);
      check("R1 reset value", v, 32'd0);
    end
    check("R1 no request after reset", {31'b0, ireq}, 32'd0);
    hwr(0, 32'h0000_00AB);
    hwr(1, 32'hCAFE_F00D);
    hrd(0, v); check("R1 address readback", v, 32'h0000_00AB);
    hrd(1, v); check("R1 data readback", v, 32'hCAFE_F00D);
    for (int a = 5; a < 8; a++) begin
      hrd(a, v);
      check("R1 unmapped offset", v, 32'd0);
    end

    // directed corners first, then random
    access(1'b0, 3, 0);
    access(1'b1, 3, 32'hDEAD_BEEF);
    access(1'b0, 3, 0);
    access(1'b1, 15, 32'hFFFF_FFFF);
    access(1'b0, 0, 0);

    // R5: reserved codes while idle
    acc0 = n_acc;
    foreach (v[i]) begin end
    for (int k = 0; k < 3; k++) begin
      hwr(2, (k == 0) ? 32'd3 : (k == 1) ? 32'd5 : 32'hFFFF_FFFF);
      repeat (4) @(negedge clk);
      check("R5 no request on reserved code", {31'b0, ireq}, 32'd0);
      hrd(2, v); check("R5 command stays zero", v, 32'd0);
      hrd(3, v); check("R5 flag stays zero", v, 32'd0);
    end
    check("R5 no access issued", n_acc, acc0);

    // R6/R5/R7: lock while the target is stalled
    stall = 1'b1;
    hwr(0, 5);
    hwr(1, 32'h1234_5678);
    hwr(2, 2);
    repeat (5) @(negedge clk);
    check("R7 request held while stalled", {31'b0, ireq}, 32'd1);
    hrd(3, v); check("R2 no completion before ack", v, 32'd0);
    hwr(0, 9);
    hwr(1, 32'h8765_4321);
    hwr(2, 1);
    check("R6 port address locked", {16'b0, iaddr}, 32'd5);
    check("R6 port data locked", iwdata, 32'h1234_5678);
    check("R5 busy command ignored", {31'b0, iwe}, 32'd1);
    hrd(0, v); check("R6 address readback locked", v, 32'd5);
    hrd(1, v); check("R6 data readback locked", v, 32'h1234_5678);
    hrd(2, v); check("R5 command keeps code", v, 32'd2);
    stall = 1'b0;
    poll_done(ok);
    check("R2 completion after release", {31'b0, ok}, 32'd1);
    shadow[5] = 32'h1234_5678;
    hwr(2, 0);
    access(1'b0, 9, 0);
    access(1'b0, 5, 0);

    // R8: early close with the target stalled
    acc0 = n_acc;
    stall = 1'b1;
    hwr(0, 7);
    hwr(1, 32'h0BAD_C0DE);
    hwr(2, 2);
    repeat (3) @(negedge clk);
    hwr(2, 0);
    repeat (3) @(negedge clk);
    check("R8 request kept after early close", {31'b0, ireq}, 32'd1);
    hrd(3, v); check("R8 flag low while pending", v, 32'd0);
    stall = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 request dropped after ack", {31'b0, ireq}, 32'd0);
    check("R8 access reached target", n_acc, acc0 + 1);
    hrd(3, v); check("R8 no completion after early close", v, 32'd0);
    hrd(2, v); check("R8 command reads zero", v, 32'd0);
    shadow[7] = 32'h0BAD_C0DE;
    access(1'b0, 7, 0);

    // random mix
    for (int t = 0; t < 60; t++) begin
      access(1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule